// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel

This block is one channel of a bus-master DMA engine for an ATA-style disk port. Software places a table of memory regions in memory. Each region is described by a buffer address and a byte count, and the last region carries an end flag. Software writes the table location into the channel's small I/O window, chooses a direction and sets the start bit. The channel then works through the table on its own. It fetches each entry through a memory read port and moves the region as a stream of 16-bit words, one word per handshake on the data side.

While the channel runs, the device's interrupt line is watched. If the device interrupts, the channel notes the event and halts. A failed descriptor fetch also halts the channel, and software can abort at any time by clearing the start bit. Software follows progress through an active bit and through two event bits, interrupt and error, which it clears by writing ones to them. Three capability bits in the same status register are plain storage that software owns.

The window sits on an 8-byte aligned base, so the block decodes only byte offset bits [2:1]. Every access is 16 bits wide.

Top module: `bmide_dma`

## Requirements
- R1: After reset the command register, the status register and both halves of the table pointer read as zero. The outputs mem_req and xfer_valid are low.
- R2: Register map:
  - Offset 0 is the command register: bit 0 is start and bit 3 is direction (1 means device to memory).
  - Offset 2 is the status register: bit 0 is active, bit 1 is error, bit 2 is interrupt, and bits 7:5 are capability flags.
  - Offsets 4 and 6 hold the low and high halves of the table pointer. Bits 1:0 of the pointer always read as 0.
- R3: A write that takes command bit 0 from 0 to 1 sets active and starts a table walk at the pointer. Each entry's address word is read at the entry base and its count word at base+4. Writing 1 again while the bit is already 1 starts nothing.
- R4: Within a region, words are offered on xfer_addr starting at the entry address with bit 0 cleared, and the address rises by 2 after each accepted word. xfer_to_mem equals command bit 3.
- R5: The region length in bytes is bits 15:0 of the count word with bit 0 cleared. A value of 0 after clearing means 65536 bytes.
- R6: After a region completes, the next entry is read 8 bytes further on. When the region whose count word has bit 31 set completes, active clears and no further fetch is issued.
- R7: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 to either bit leaves it unchanged, and bit 0 is not affected by status writes.
- R8: Status bits 7:5 take the value written to the status register and hold it until the next status write.
- R9: Status bit 2 is set in the cycle after dev_irq is seen high, and a set in the same cycle as a clear-by-write wins. If dev_irq is high while the channel is active, active clears and no more words are offered.
- R10: A descriptor fetch that completes with mem_err high sets status bit 1, clears active and moves no data.
- R11: Writing 0 to command bit 0 while the channel is active clears active, and no further words are offered.
- R12: A command write made while the channel is active does not change the direction bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset within the register window |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the register at reg_addr |
| mem_req | output | 1 | Descriptor word fetch request |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Fetch completes this cycle |
| mem_rdata | input | 32 | Fetched descriptor word |
| mem_err | input | 1 | Fetch completed with an error response |
| xfer_valid | output | 1 | A data word is offered |
| xfer_addr | output | 32 | Memory byte address of the offered word |
| xfer_to_mem | output | 1 | Word moves from device to memory |
| xfer_ready | input | 1 | Offered word is accepted this cycle |
| dev_irq | input | 1 | Device interrupt line |

## Verification
The interrupt flag can be set by dev_irq and cleared by a status write in the same cycle. The bench provokes this by raising dev_irq in the very cycle that writes 1 to bit 2. It then expects the bit to read 1, and a later write on its own must read back 0. In a second collision, a device interrupt or a start-bit clear lands while words are flowing. The bench judges this by the word count. The count must stop growing, it must stay short of the region length, and active must read 0.

// File: rtl/bmide_dma.sv
module bmide_dma #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              xfer_to_mem,
  input  logic              xfer_ready,
  input  logic              dev_irq
);
  localparam int REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] FULL = REM_W'(1) << CNT_W;

  typedef enum logic [1:0] {S_IDLE, S_FADDR, S_FCNT, S_MOVE} st_t;

  st_t               st;
  logic              start_q, dir_q, active, err_q, irq_q, last_q;
  logic [2:0]        caps_q;
  logic [ADDR_W-1:0] tbl_q, walk_q, cur_q;
  logic [REM_W-1:0]  rem_q;
  logic [CNT_W-1:0]  cnt_even;

  wire wr_cmd = reg_wr && reg_addr[2:1] == 2'd0;
  wire wr_sts = reg_wr && reg_addr[2:1] == 2'd1;
  wire wr_plo = reg_wr && reg_addr[2:1] == 2'd2;
  wire wr_phi = reg_wr && reg_addr[2:1] == 2'd3;
  wire launch = wr_cmd && reg_wdata[0] && !start_q;
  wire halt   = active && ((wr_cmd && !reg_wdata[0]) || dev_irq);

  assign cnt_even    = {mem_rdata[CNT_W-1:1], 1'b0};
  assign mem_req     = st == S_FADDR || st == S_FCNT;
  assign mem_addr    = st == S_FCNT ? walk_q + ADDR_W'(4) : walk_q;
  assign xfer_valid  = st == S_MOVE;
  assign xfer_addr   = cur_q;
  assign xfer_to_mem = dir_q;

  always_comb begin
    case (reg_addr[2:1])
      2'd0:    reg_rdata = {12'd0, dir_q, 2'b00, start_q};
      2'd1:    reg_rdata = {8'd0, caps_q, 2'b00, irq_q, err_q, active};
      2'd2:    reg_rdata = tbl_q[15:0];
      default: reg_rdata = tbl_q[31:16];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      start_q <= 1'b0;
      dir_q <= 1'b0;
      active <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      last_q <= 1'b0;
      caps_q <= '0;
      tbl_q <= '0;
      walk_q <= '0;
      cur_q <= '0;
      rem_q <= '0;
    end else begin
      if (wr_plo) tbl_q[15:0] <= {reg_wdata[15:2], 2'b00};
      if (wr_phi) tbl_q[31:16] <= reg_wdata;
      if (wr_sts) caps_q <= reg_wdata[7:5];
      irq_q <= dev_irq || (irq_q && !(wr_sts && reg_wdata[2]));
      if (wr_sts && reg_wdata[1]) err_q <= 1'b0;
      if (wr_cmd) begin
        start_q <= reg_wdata[0];
        if (!active) dir_q <= reg_wdata[3];
      end
      if (launch) begin
        active <= 1'b1;
        walk_q <= tbl_q;
        st <= S_FADDR;
      end else if (halt) begin
        active <= 1'b0;
        st <= S_IDLE;
      end else begin
        case (st)
          S_FADDR: if (mem_ack) begin
            if (mem_err) begin
              err_q <= 1'b1;
              active <= 1'b0;
              st <= S_IDLE;
            end else begin
              cur_q <= {mem_rdata[ADDR_W-1:1], 1'b0};
              st <= S_FCNT;
            end
          end
          S_FCNT: if (mem_ack) begin
            if (mem_err) begin
              err_q <= 1'b1;
              active <= 1'b0;
              st <= S_IDLE;
            end else begin
              rem_q <= cnt_even == '0 ? FULL : REM_W'(cnt_even);
              last_q <= mem_rdata[31];
              st <= S_MOVE;
            end
          end
          S_MOVE: if (xfer_ready) begin
            cur_q <= cur_q + ADDR_W'(2);
            rem_q <= rem_q - REM_W'(2);
            if (rem_q == REM_W'(2)) begin
              if (last_q) begin
                active <= 1'b0;
                st <= S_IDLE;
              end else begin
                walk_q <= walk_q + ADDR_W'(8);
                st <= S_FADDR;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module bmide_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic        active,
  input logic        err_q,
  input logic        irq_q,
  input logic        dir_q,
  input logic [2:0]  caps_q,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_err,
  input logic        xfer_valid,
  input logic [31:0] xfer_addr,
  input logic        dev_irq
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || xfer_valid) |-> active);
  assert_even_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !xfer_addr[0]);
  assert_one_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xfer_valid));
  assert_caps_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr[2:1] == 2'd1) |=> $stable(caps_q));
  assert_irq_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq |=> irq_q);
  assert_irq_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dev_irq) |=> !active);
  assert_fetch_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err && !reg_wr && !dev_irq) |=> (err_q && !active));
  assert_dir_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(dir_q));
endmodule

bind bmide_dma bmide_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .active(active), .err_q(err_q), .irq_q(irq_q), .dir_q(dir_q),
  .caps_q(caps_q), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_err(mem_err), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
  .dev_irq(dev_irq)
);

// File: tb/sim_bmide_dma.sv
`timescale 1ns/1ps
module sim_bmide_dma;
  localparam logic [31:0] TBASE = 32'h0000_1000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        mem_req, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_rdata;
  logic        xfer_valid, xfer_to_mem;
  logic [31:0] xfer_addr;
  logic        xfer_ready = 1'b1;
  logic        dev_irq = 1'b0;

  logic [31:0] tmem [0:7];
  logic [31:0] err_at = 32'hFFFF_FFFF;
  logic [31:0] ea [0:3];
  logic [31:0] ec [0:3];
  logic [31:0] got [0:63];
  logic [31:0] last_addr;
  int n = 0, dir_bad = 0, fetches = 0, rdy_rand = 0, exp_dir = 0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bmide_dma u0 (.*);

  always_comb begin
    logic [31:0] off;
    off = (mem_addr - TBASE) >> 2;
    mem_ack = mem_req;
    mem_err = mem_req && mem_addr == err_at;
    mem_rdata = off < 8 ? tmem[off[2:0]] : 32'hDEAD_BEEF;
  end

  always @(negedge clk) begin
    if (mem_req) fetches++;
    if (xfer_valid && xfer_ready) begin
      if (n < 64) got[n] = xfer_addr;
      last_addr = xfer_addr;
      if (int'(xfer_to_mem) != exp_dir) dir_bad++;
      n++;
    end
  end

  initial forever begin
    @(posedge clk);
    #2 xfer_ready = rdy_rand != 0 ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input int limit);
    logic [15:0] s;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk); rd(3'd2, s);
      if (!s[0]) break;
    end
  endtask

  function automatic int region_bytes(input logic [31:0] cw);
    logic [15:0] c;
    c = {cw[15:1], 1'b0};
    return c == 16'd0 ? 65536 : int'(c);
  endfunction

  task automatic load_table(input int ne);
    for (int e = 0; e < 4; e++) begin
      tmem[2*e]   = e < ne ? ea[e] : 32'h0;
      tmem[2*e+1] = e < ne ? (ec[e] | (e == ne - 1 ? 32'h8000_0000 : 32'h0)) : 32'h0;
    end
  endtask

  task automatic start(input int dir);
    wr(3'd4, TBASE[15:0]); wr(3'd6, TBASE[31:16]);
    wr(3'd0, 16'(dir << 3));
    n = 0; dir_bad = 0; fetches = 0; exp_dir = dir;
    wr(3'd0, 16'((dir << 3) | 1));
  endtask

  task automatic verify_run(input int ne, input string tag);
    int idx, bad;
    logic [31:0] first_bad_got, first_bad_exp;
    logic [15:0] s;
    idx = 0; bad = 0; first_bad_got = 0; first_bad_exp = 0;
    for (int e = 0; e < ne; e++) begin
      for (int w = 0; w < region_bytes(ec[e]) / 2; w++) begin
        if (idx < 64 && got[idx] !== (ea[e] & ~32'h1) + 32'(2 * w)) begin
          if (bad == 0) begin first_bad_got = got[idx]; first_bad_exp = (ea[e] & ~32'h1) + 32'(2 * w); end
          bad++;
        end
        idx++;
      end
    end
    chk({tag, " R4 address sequence"}, first_bad_got, first_bad_exp);
    chk({tag, " R5 word count"}, 32'(n), 32'(idx));
    chk({tag, " R6 descriptor fetches"}, 32'(fetches), 32'(2 * ne));
    chk({tag, " R4 direction"}, 32'(dir_bad), 32'd0);
    rd(3'd2, s);
    chk({tag, " R6 active clear, no events"}, {29'd0, s[2:0]}, 32'd0);
  endtask

  initial begin
    logic [15:0] s;
    int k;
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] s;
    int k;
    void'($urandom(32'd7321));
    for (int i = 0; i < 8; i++) tmem[i] = 32'h0;
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, s); chk("R1 command reset", {16'd0, s}, 32'd0);
    rd(3'd2, s); chk("R1 status reset", {16'd0, s}, 32'd0);
    rd(3'd4, s); chk("R1 pointer low reset", {16'd0, s}, 32'd0);
    rd(3'd6, s); chk("R1 pointer high reset", {16'd0, s}, 32'd0);
    chk("R1 ports idle", {30'd0, mem_req, xfer_valid}, 32'd0);

    wr(3'd4, 16'h1237); wr(3'd6, 16'hABCD); wr(3'd0, 16'h0008);
    @(negedge clk);
    rd(3'd4, s); chk("R2 pointer low bits", {16'd0, s}, 32'h1234);
    rd(3'd6, s); chk("R2 pointer high", {16'd0, s}, 32'hABCD);
    rd(3'd0, s); chk("R2 direction readback", {16'd0, s}, 32'h0008);

    ea[0] = 32'h2000; ec[0] = 32'd6; ea[1] = 32'h3001; ec[1] = 32'd5;
    load_table(2); rdy_rand = 0;
    start(1); wait_idle(200);
    verify_run(2, "directed");

    wr(3'd0, 16'h0009); @(negedge clk);
    rd(3'd2, s); chk("R3 no restart on repeated 1", {31'd0, s[0]}, 32'd0);
    chk("R3 no fetch on repeated 1", 32'(fetches), 32'd4);

    for (int r = 0; r < 8; r++) begin
      k = $urandom_range(1, 3);
      for (int e = 0; e < k; e++) begin
        ea[e] = 32'h0001_0000 + 32'($urandom_range(0, 4095)) * 32'd16 + 32'($urandom_range(0, 1));
        ec[e] = 32'($urandom_range(2, 30)) | (32'($urandom_range(0, 255)) << 16);
      end
      load_table(k); rdy_rand = 1;
      start(int'($urandom_range(0, 1)));
      wait_idle(2000);
      verify_run(k, "random");
    end

    ea[0] = 32'h0004_0000; ec[0] = 32'h0000_0001; load_table(1); rdy_rand = 0;
    start(0); wait_idle(70000);
    chk("R5 zero length is 65536 bytes", 32'(n), 32'd32768);
    chk("R5 last word address", last_addr, 32'h0004_FFFE);

    ea[0] = 32'h5000; ec[0] = 32'd64; load_table(1);
    start(0);
    while (n < 5) @(negedge clk);
    @(posedge clk); #1 dev_irq = 1'b1;
    @(posedge clk); #1 dev_irq = 1'b0;
    k = n; repeat (20) @(negedge clk);
    chk("R9 no words after interrupt", 32'(n), 32'(k));
    chk("R9 halted short of region", 32'(n < 32), 32'd1);
    rd(3'd2, s); chk("R9 status after interrupt", {29'd0, s[2:0]}, 32'h4);

    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h0004; dev_irq = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0; dev_irq = 1'b0;
    @(negedge clk); rd(3'd2, s); chk("R9 set beats clear", {31'd0, s[2]}, 32'd1);
    wr(3'd2, 16'h0000); @(negedge clk);
    rd(3'd2, s); chk("R7 zero write keeps interrupt", {31'd0, s[2]}, 32'd1);
    wr(3'd2, 16'h0004); @(negedge clk);
    rd(3'd2, s); chk("R7 clear interrupt", {31'd0, s[2]}, 32'd0);

    start(0);
    while (n < 3) @(negedge clk);
    wr(3'd0, 16'h0000);
    k = n; repeat (20) @(negedge clk);
    chk("R11 no words after abort", 32'(n), 32'(k));
    rd(3'd2, s); chk("R11 abort clears active only", {29'd0, s[2:0]}, 32'd0);

    rdy_rand = 1; start(0);
    while (n < 2) @(negedge clk);
    wr(3'd0, 16'h0009); @(negedge clk);
    rd(3'd0, s); chk("R12 direction held while active", {31'd0, s[3]}, 32'd0);
    wait_idle(500);
    chk("R12 stream direction unchanged", 32'(dir_bad), 32'd0);
    chk("R12 region completes", 32'(n), 32'd32);

    err_at = TBASE + 32'd4; rdy_rand = 0;
    start(1); wait_idle(50);
    chk("R10 no data on fetch error", 32'(n), 32'd0);
    rd(3'd2, s); chk("R10 error set, inactive", {29'd0, s[2:0]}, 32'h2);
    wr(3'd2, 16'h0002); @(negedge clk);
    rd(3'd2, s); chk("R7 clear error", {31'd0, s[1]}, 32'd0);
    err_at = 32'hFFFF_FFFF;

    wr(3'd2, 16'h00E6); @(negedge clk);
    rd(3'd2, s); chk("R8 capability bits set", {24'd0, s[7:0]}, 32'hE0);
    wr(3'd2, 16'h0060); @(negedge clk);
    rd(3'd2, s); chk("R8 capability bits rewritten", {24'd0, s[7:0]}, 32'h60);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule